// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block holds the host-visible programming state of a four-channel DMA engine and steps each channel through its transfer. A host writes byte-wide registers at 11-bit I/O addresses. Each channel has a 16-bit current address and a 16-bit count. Both are reached through one 8-bit port each, and a shared byte pointer picks the low or high half. The count is programmed as the byte total minus one. The block also holds:

- a per-channel mode register;
- a per-channel mask bit, set through a single-channel mask port;
- a sticky status byte of terminal-count flags;
- a pair of page bytes per channel, which supply address bits 31:16.

Peripherals raise `dreq`. The lowest-numbered unmasked requester is granted on `dack`, and the granted transfer is offered downstream as a valid/ready beat. `xfer_valid` is high while a grant stands. A beat completes only in a cycle where `xfer_ready` is also high. Holding `xfer_ready` low stalls the channel with its address and count unchanged, and the grant may move to another channel if requests change. On each completed beat the address counts up and the count counts down. The beat that finds the count at zero is the last one. It raises `tc`, sets the channel's status flag and masks the channel.

Top module: `dma4_regfile`

## Requirements
- R1: After reset all four channels are masked, the status byte reads 0x00, the byte pointer selects the low byte, and `dack` and `xfer_valid` stay low whatever `dreq` does.
- R2: Channel n has its address port at 2n and its count port at 2n+1. Each read or write of any of these eight ports uses the low byte when the byte pointer is clear and the high byte when it is set. The access then toggles the pointer. A write of any value to 0x0C clears the pointer.
- R3: A write to 0x0B stores bits 7:2 as the mode of the channel named in bits 1:0. While that channel is granted, `xfer_type` shows mode bits 3:2: 01 means device to memory and 10 means memory to device.
- R4: A write to 0x0A selects a channel with bits 1:0. It masks that channel when bit 2 is 1 and unmasks it when bit 2 is 0. Other channels keep their mask bits.
- R5: A channel is eligible when its `dreq` is high and it is unmasked. Of the eligible channels, the lowest-numbered one wins. `dack` is at most one-hot, and `xfer_valid`, `xfer_chan` and `xfer_addr` describe the winner in the same cycle.
- R6: A beat completes in a cycle where `xfer_valid` and `xfer_ready` are both high. The granted channel's address then increments with 16-bit wrap and its count decrements. A cycle with `xfer_ready` low changes neither.
- R7: A beat that finds the count at 0x0000 is the terminal beat. In that cycle the channel's `tc` bit is high. Afterwards the count reads 0xFFFF, the channel's status flag is set and the channel is masked, so a programmed count N yields N+1 beats.
- R8: A read of 0x08 returns the terminal-count flags in bits 3:0 (bit n for channel n) and zeros in bits 7:4, then clears the flags. A flag raised by a terminal beat in the same cycle as the read is kept.
- R9: A write to 0x0D masks all channels and clears the byte pointer and the status flags. Address, count, mode and page contents are kept.
- R10: Channel n's low page byte is at 0x080+P(n) and its high page byte is at 0x480+P(n), with P = 7, 3, 1, 2 for channels 0 to 3. Both page bytes are readable. `xfer_addr` is {high page, low page, 16-bit address}.
- R11: Read data appears on `host_rdata`, with `host_rvalid` high, in the cycle after `host_rd_en`. An unmapped address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 11 | Host I/O address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, one cycle after the read strobe |
| host_rvalid | output | 1 | Marks valid read data |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel grant, at most one-hot |
| tc | output | 4 | Terminal-beat indication per channel |
| xfer_valid | output | 1 | A granted beat is offered |
| xfer_ready | input | 1 | Downstream accepts the beat |
| xfer_chan | output | 2 | Granted channel number |
| xfer_addr | output | 32 | Full address of the offered beat |
| xfer_type | output | 2 | Direction field of the granted channel's mode |

## Verification
Some properties are checked on every cycle:
- the grant is at most one-hot, and it only goes to a requesting, unmasked channel that has no lower-numbered rival;
- each completed beat moves address and count by one, and a stalled cycle moves neither;
- a terminal beat leaves its channel masked;
- a master clear leaves all masks set with status and pointer cleared.

Other behaviours depend on sequences of host accesses, so only the directed scenarios can show them:
- which byte a port reaches after a series of accesses across different channels;
- the count-minus-one beat total;
- the read-to-clear status, including a flag raised in the same cycle as its read;
- readback of page bytes and the full address on the transfer port.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int NCH = 4;
  localparam int CHW = 2;
  localparam int DW  = 8;
  localparam int CW  = 16;
  localparam int HAW = 11;

  localparam logic [HAW-1:0] A_STATUS = 11'h008;
  localparam logic [HAW-1:0] A_MASK   = 11'h00A;
  localparam logic [HAW-1:0] A_MODE   = 11'h00B;
  localparam logic [HAW-1:0] A_PTRCLR = 11'h00C;
  localparam logic [HAW-1:0] A_MCLR   = 11'h00D;
  localparam logic [HAW-1:0] A_PGLO   = 11'h080;
  localparam logic [HAW-1:0] A_PGHI   = 11'h480;

  typedef enum logic [1:0] {
    XT_CHECK    = 2'b00,
    XT_TO_MEM   = 2'b01,
    XT_FROM_MEM = 2'b10,
    XT_RSVD     = 2'b11
  } xfer_kind_e;

  typedef struct packed {
    logic [NCH-1:0] addr_wr;
    logic [NCH-1:0] cnt_wr;
    logic [NCH-1:0] pglo_wr;
    logic [NCH-1:0] pghi_wr;
    logic           mode_wr;
    logic           mask_wr;
    logic           ptr_clr;
    logic           mclr;
    logic           stat_rd;
    logic           ptr_step;
  } host_strb_t;

  function automatic logic [3:0] page_slot(input int ch);
    case (ch)
      0:       page_slot = 4'h7;
      1:       page_slot = 4'h3;
      2:       page_slot = 4'h1;
      default: page_slot = 4'h2;
    endcase
  endfunction
endpackage

// File: rtl/dma4_host_decode.sv
module dma4_host_decode
  import dma4_pkg::*;
#(
  parameter int N_CH   = NCH,
  parameter int ADDR_W = HAW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output host_strb_t        strb
);
  localparam int SELW = $clog2(N_CH);

  logic            in_chan_win;
  logic [SELW-1:0] sel;

  assign in_chan_win = (addr[ADDR_W-1:SELW+1] == '0);
  assign sel         = addr[SELW:1];

  always_comb begin
    strb = '0;
    if (in_chan_win) begin
      strb.ptr_step = wr_en | rd_en;
      if (wr_en) begin
        if (addr[0]) strb.cnt_wr[sel]  = 1'b1;
        else         strb.addr_wr[sel] = 1'b1;
      end
    end
    for (int i = 0; i < N_CH; i++) begin
      if (wr_en && addr == (A_PGLO + ADDR_W'(page_slot(i)))) strb.pglo_wr[i] = 1'b1;
      if (wr_en && addr == (A_PGHI + ADDR_W'(page_slot(i)))) strb.pghi_wr[i] = 1'b1;
    end
    strb.mode_wr = wr_en && addr == A_MODE;
    strb.mask_wr = wr_en && addr == A_MASK;
    strb.ptr_clr = wr_en && addr == A_PTRCLR;
    strb.mclr    = wr_en && addr == A_MCLR;
    strb.stat_rd = rd_en && addr == A_STATUS;
  end

  // R2: a host write lands in at most one register
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.addr_wr, strb.cnt_wr, strb.pglo_wr, strb.pghi_wr,
              strb.mode_wr, strb.mask_wr, strb.ptr_clr, strb.mclr}));
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int N_CH = 4,
  localparam int SELW = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] elig,
  output logic [N_CH-1:0] gnt,
  output logic [SELW-1:0] gnt_idx,
  output logic            gnt_any
);
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        gnt     = '0;
        gnt[i]  = 1'b1;
        gnt_idx = SELW'(i);
      end
    end
  end
  assign gnt_any = |elig;

  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  a_r5_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~elig) == '0);
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> ((elig & (gnt - 1'b1)) == '0));
  a_r5_valid_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any == (gnt != '0));
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan #(
  parameter int BW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] wdata,
  input  logic          hi_sel,
  input  logic          addr_wr,
  input  logic          cnt_wr,
  input  logic          pglo_wr,
  input  logic          pghi_wr,
  input  logic          mode_hit,
  input  logic          mask_hit,
  input  logic          mask_val,
  input  logic          mclr,
  input  logic          beat,
  output logic [CW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic [BW-1:0] pglo_q,
  output logic [BW-1:0] pghi_q,
  output logic [1:0]    kind,
  output logic          mask_q,
  output logic          tc_hit
);
  localparam int MODEW = BW - 2;

  logic [MODEW-1:0] mode_q;

  assign tc_hit = beat && (cnt_q == '0);
  assign kind   = mode_q[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (addr_wr) begin
        if (hi_sel) addr_q[CW-1:BW] <= wdata;
        else        addr_q[BW-1:0]  <= wdata;
      end else if (beat) begin
        addr_q <= addr_q + 1'b1;
      end
      if (cnt_wr) begin
        if (hi_sel) cnt_q[CW-1:BW] <= wdata;
        else        cnt_q[BW-1:0]  <= wdata;
      end else if (beat) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pglo_q <= '0;
      pghi_q <= '0;
      mode_q <= '0;
    end else begin
      if (pglo_wr)  pglo_q <= wdata;
      if (pghi_wr)  pghi_q <= wdata;
      if (mode_hit) mode_q <= wdata[BW-1:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        mask_q <= 1'b1;
    else if (mclr)     mask_q <= 1'b1;
    else if (tc_hit)   mask_q <= 1'b1;
    else if (mask_hit) mask_q <= mask_val;
  end

  a_r5_no_beat_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> !mask_q);
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !cnt_wr) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !addr_wr) |=> addr_q == $past(addr_q) + 1'b1);
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !cnt_wr && !addr_wr) |=> ($stable(cnt_q) && $stable(addr_q)));
  a_r7_self_mask: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit |=> mask_q);
endmodule

// File: rtl/dma4_regfile.sv
module dma4_regfile
  import dma4_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_wr_en,
  input  logic           host_rd_en,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_rvalid,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic [NCH-1:0] tc,
  output logic           xfer_valid,
  input  logic           xfer_ready,
  output logic [CHW-1:0] xfer_chan,
  output logic [2*DW+CW-1:0] xfer_addr,
  output logic [1:0]     xfer_type
);
  host_strb_t     strb;
  logic           ptr_hi;
  logic [NCH-1:0] flags;
  logic [NCH-1:0] mask_v;
  logic [NCH-1:0] tc_v;
  logic [NCH-1:0] gnt;
  logic [NCH-1:0] beat_v;
  logic [CHW-1:0] gidx;
  logic           gany;
  logic [CW-1:0]  ch_addr [NCH];
  logic [CW-1:0]  ch_cnt  [NCH];
  logic [DW-1:0]  ch_pglo [NCH];
  logic [DW-1:0]  ch_pghi [NCH];
  logic [1:0]     ch_kind [NCH];
  logic [DW-1:0]  rd_mux;

  dma4_host_decode #(.N_CH(NCH), .ADDR_W(HAW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .rd_en(host_rd_en),
    .addr(host_addr), .strb(strb)
  );

  dma4_arb #(.N_CH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(dreq & ~mask_v),
    .gnt(gnt), .gnt_idx(gidx), .gnt_any(gany)
  );

  assign beat_v = gnt & {NCH{xfer_ready}};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic mode_hit_g;
    logic mask_hit_g;
    assign mode_hit_g = strb.mode_wr && host_wdata[CHW-1:0] == CHW'(g);
    assign mask_hit_g = strb.mask_wr && host_wdata[CHW-1:0] == CHW'(g);
    dma4_chan #(.BW(DW), .CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .wdata(host_wdata), .hi_sel(ptr_hi),
      .addr_wr(strb.addr_wr[g]), .cnt_wr(strb.cnt_wr[g]),
      .pglo_wr(strb.pglo_wr[g]), .pghi_wr(strb.pghi_wr[g]),
      .mode_hit(mode_hit_g), .mask_hit(mask_hit_g), .mask_val(host_wdata[CHW]),
      .mclr(strb.mclr), .beat(beat_v[g]),
      .addr_q(ch_addr[g]), .cnt_q(ch_cnt[g]), .pglo_q(ch_pglo[g]),
      .pghi_q(ch_pghi[g]), .kind(ch_kind[g]), .mask_q(mask_v[g]),
      .tc_hit(tc_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         ptr_hi <= 1'b0;
    else if (strb.mclr || strb.ptr_clr) ptr_hi <= 1'b0;
    else if (strb.ptr_step)             ptr_hi <= ~ptr_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         flags <= '0;
    else if (strb.mclr) flags <= '0;
    else                flags <= (strb.stat_rd ? '0 : flags) | tc_v;
  end

  always_comb begin
    logic [CHW-1:0] s;
    logic [CW-1:0]  w;
    s      = host_addr[CHW:1];
    w      = host_addr[0] ? ch_cnt[s] : ch_addr[s];
    rd_mux = '0;
    if (host_addr[HAW-1:CHW+1] == '0) rd_mux = ptr_hi ? w[CW-1:DW] : w[DW-1:0];
    else if (host_addr == A_STATUS)   rd_mux = DW'(flags);
    for (int i = 0; i < NCH; i++) begin
      if (host_addr == (A_PGLO + HAW'(page_slot(i)))) rd_mux = ch_pglo[i];
      if (host_addr == (A_PGHI + HAW'(page_slot(i)))) rd_mux = ch_pghi[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd_en;
      if (host_rd_en) host_rdata <= rd_mux;
    end
  end

  assign dack       = gnt;
  assign tc         = tc_v;
  assign xfer_valid = gany;
  assign xfer_chan  = gidx;
  assign xfer_addr  = {ch_pghi[gidx], ch_pglo[gidx], ch_addr[gidx]};
  assign xfer_type  = ch_kind[gidx];

  a_r9_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
    strb.mclr |=> (&mask_v && flags == '0 && !ptr_hi));
  a_r2_pointer_clear: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ptr_clr |=> !ptr_hi);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stat_rd && tc_v == '0) |=> flags == '0);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_v != '0) |=> ((flags & $past(tc_v)) == $past(tc_v)) || $past(strb.mclr));
  a_r11_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en |=> host_rvalid);
endmodule

// File: tb/dma4_regfile_tb_top.sv
module dma4_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [10:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack, tc;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [1:0]  xfer_chan, xfer_type;
  logic [31:0] xfer_addr;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  dma4_regfile dut_i (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr_en = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    host_addr = a; host_rd_en = 1'b1;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rvalid ? host_rdata : 8'hxx;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    dreq = 4'hF; #1;
    chk("R1 dack masked", {27'b0, xfer_valid, dack}, 32'h0);
    dreq = 4'h0;
    rd(11'h008, d); chk("R1 status", d, 8'h00);
    rd(11'h00F, d); chk("R11 unmapped", d, 8'h00);
  endtask

  task automatic t_byte_ptr();
    logic [7:0] d;
    wr(11'h00C, 8'h00);
    wr(11'h002, 8'h34); wr(11'h002, 8'h12);
    wr(11'h00C, 8'h00);
    wr(11'h004, 8'h77);
    wr(11'h006, 8'h99);
    wr(11'h00C, 8'h00);
    rd(11'h002, d); chk("R2 ch1 addr lo", d, 8'h34);
    rd(11'h002, d); chk("R2 ch1 addr hi", d, 8'h12);
    rd(11'h006, d); chk("R2 ch3 addr lo", d, 8'h00);
    rd(11'h006, d); chk("R2 ch3 addr hi", d, 8'h99);
    wr(11'h00C, 8'h00);
    rd(11'h004, d); chk("R2 ch2 addr lo", d, 8'h77);
  endtask

  task automatic t_terminal();
    logic [7:0] d;
    wr(11'h00C, 8'h00);
    wr(11'h004, 8'h10); wr(11'h004, 8'h00);
    wr(11'h005, 8'h02); wr(11'h005, 8'h00);
    wr(11'h081, 8'hAB); wr(11'h481, 8'hCD);
    wr(11'h00B, 8'h46);
    wr(11'h00A, 8'h02);
    dreq = 4'b0100; xfer_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R10 xfer_addr", xfer_addr, 32'hCDAB_0010 + 32'(k));
      chk("R7 tc pulse", {28'b0, tc}, (k == 2) ? 32'h4 : 32'h0);
      chk("R3 type to-mem", {30'b0, xfer_type}, 32'h1);
      @(negedge clk);
    end
    #1; chk("R7 self mask", {28'b0, dack}, 32'h0);
    dreq = 4'b0000; xfer_ready = 1'b0;
    rd(11'h008, d); chk("R8 flag ch2", d, 8'h04);
    rd(11'h008, d); chk("R8 cleared", d, 8'h00);
    wr(11'h00C, 8'h00);
    rd(11'h005, d); chk("R7 count lo wrap", d, 8'hFF);
    rd(11'h005, d); chk("R7 count hi wrap", d, 8'hFF);
    rd(11'h004, d); chk("R6 addr lo", d, 8'h13);
    rd(11'h081, d); chk("R10 page lo", d, 8'hAB);
    rd(11'h481, d); chk("R10 page hi", d, 8'hCD);
    wr(11'h00B, 8'h4A); wr(11'h00A, 8'h02);
    dreq = 4'b0100; #1;
    chk("R3 type from-mem", {30'b0, xfer_type}, 32'h2);
    dreq = 4'b0000;
    wr(11'h00A, 8'h06);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(11'h00C, 8'h00);
    wr(11'h003, 8'h00); wr(11'h003, 8'h10);
    wr(11'h007, 8'h00); wr(11'h007, 8'h10);
    wr(11'h00A, 8'h01); wr(11'h00A, 8'h03);
    dreq = 4'b1010; xfer_ready = 1'b0; #1;
    chk("R5 lowest wins", {28'b0, dack}, 32'h2);
    chk("R5 chan", {30'b0, xfer_chan}, 32'h1);
    chk("R5 addr ch1", xfer_addr[15:0], 32'h1234);
    @(negedge clk); #1;
    chk("R6 stall holds", xfer_addr[15:0], 32'h1234);
    xfer_ready = 1'b1; @(negedge clk); #1;
    chk("R6 step", xfer_addr[15:0], 32'h1235);
    xfer_ready = 1'b0;
    dreq = 4'b0000;
    wr(11'h00A, 8'h05);
    dreq = 4'b1010; #1;
    chk("R4 masked ch1 skipped", {28'b0, dack}, 32'h8);
    chk("R5 valid", {31'b0, xfer_valid}, 32'h1);
    dreq = 4'b0000;
    wr(11'h00C, 8'h00);
    rd(11'h003, d); chk("R6 count lo", d, 8'hFF);
    rd(11'h003, d); chk("R6 count hi", d, 8'h0F);
  endtask

  task automatic t_same_cycle_flag();
    logic [7:0] d;
    wr(11'h00C, 8'h00);
    wr(11'h001, 8'h00); wr(11'h001, 8'h00);
    wr(11'h00A, 8'h00);
    dreq = 4'b0001; xfer_ready = 1'b1;
    rd(11'h008, d); chk("R8 read before flag", d, 8'h00);
    dreq = 4'b0000; xfer_ready = 1'b0;
    rd(11'h008, d); chk("R8 same-cycle flag kept", d, 8'h01);
  endtask

  task automatic t_master_clear();
    logic [7:0] d;
    wr(11'h000, 8'hEE);
    wr(11'h00D, 8'h00);
    dreq = 4'b1000; #1;
    chk("R9 all masked", {28'b0, dack}, 32'h0);
    dreq = 4'b0000;
    wr(11'h000, 8'h55); wr(11'h000, 8'h66);
    rd(11'h000, d); chk("R9 ptr cleared lo", d, 8'h55);
    rd(11'h000, d); chk("R9 ptr cleared hi", d, 8'h66);
    rd(11'h081, d); chk("R9 page kept", d, 8'hAB);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_ptr();
    t_terminal();
    t_priority();
    t_same_cycle_flag();
    t_master_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule